// File: doc/BRIEF.md
# SMBus Bus Time-out Monitor

This block observes already-synchronized SCL and SDA samples. It keeps track of whether a transfer is in progress and times two kinds of stall. The bus tracker detects START and STOP conditions and sets or clears a busy indication. A span timer is shared between two uses, selected by a mode input:

- In one mode it times how long SCL stays low while the bus is busy.
- In the other mode it times how long the bus stays idle.

A second, cumulative timer adds up SCL-low time across a transaction window. That window is bounded differently for the controller role and the target role.

Both timers advance only on a prescaled tick. Each timer uses a 14-bit count whose upper eight bits are compared with an 8-bit programmable limit. A time-out sets a sticky flag, which software clears with a write-1 pulse. Each flag can be routed to a shared interrupt. When the reset-on-time-out option is on, the block also requests a reset of the protocol engine, which then releases both lines high. The protocol engine itself lives outside this block.

Bus tracker states: `BUS_IDLE` goes to `BUS_ACTIVE` on START, and back on STOP or when monitoring is disabled. Span timer states: `TMR_WAIT` goes to `TMR_COUNT` on the first counted tick and to `TMR_EXPIRED` on reaching the limit; any state returns to `TMR_WAIT` when the timed condition drops. Cumulative timer states: `CUM_IDLE` goes to `CUM_WINDOW` on START from any state; `CUM_WINDOW` goes to `CUM_EXPIRED` on reaching the limit; `CUM_WINDOW` and `CUM_EXPIRED` return to `CUM_IDLE` on a window end or on disable.

Top module: `smbus_tmo_monitor`

## Requirements
- R1: START (SDA falling while SCL stays high across two samples) makes `bus_busy` 1 from the next clock; STOP (SDA rising while SCL stays high) makes it 0 from the next clock; reset value is 0.
- R2: With `idle_mode`=0 the span timer counts while `bus_busy` is 1 and SCL is low; with `idle_mode`=1 it counts while `bus_busy` is 0 and SCL and SDA are both high.
- R3: A span time-out occurs on the tick that brings the count to `bto_limit`×64 (the limit equals count bits 13:6); a limit of 0 never times out.
- R4: A span time-out sets `bto_flag` only while `bto_en` and `mon_en` are 1; the flag holds until a `bto_clr` pulse, and a set in the same cycle wins over the clear.
- R5: The SCL-low count restarts whenever SCL is sampled high; the idle count restarts whenever the bus is busy or either line is low.
- R6: After a time-out the span timer stays expired and raises no new time-out until its condition drops, even if the flag is cleared meanwhile.
- R7: The cumulative timer opens its window at START (a repeated START restarts it from 0). It closes the window at STOP, or at an `ack_i` pulse when `ctrl_role`=1. Inside the window it counts ticks with SCL low, and it sets sticky `cum_flag` (cleared by `cum_clr`) at `cum_limit`×64.
- R8: `irq` is 1 exactly when (`bto_flag` and `bto_ie`) or (`cum_flag` and `cum_ie`).
- R9: When `rst_on_to_en` is 1, `fsm_rst_req` pulses high for one cycle in the cycle after any time-out; otherwise it stays 0.
- R10: With `mon_en`=0, `bus_busy` returns to 0 on the next clock, both timers clear and no time-out occurs; existing flags are kept.
- R11: Timers advance only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| tick_i | input | 1 | Prescaled count enable |
| mon_en | input | 1 | Bus-management monitor enable |
| idle_mode | input | 1 | 0: time SCL low while busy; 1: time bus idle |
| bto_en | input | 1 | Span time-out detection enable |
| bto_ie | input | 1 | Span time-out interrupt enable |
| bto_limit | input | 8 | Span time-out limit |
| cum_en | input | 1 | Cumulative time-out enable |
| cum_ie | input | 1 | Cumulative time-out interrupt enable |
| cum_limit | input | 8 | Cumulative time-out limit |
| ctrl_role | input | 1 | 1: controller role (window ends at ACK) |
| ack_i | input | 1 | ACK-cycle pulse from the protocol engine |
| rst_on_to_en | input | 1 | Request an engine reset on time-out |
| bto_clr | input | 1 | Write-1 clear pulse for `bto_flag` |
| cum_clr | input | 1 | Write-1 clear pulse for `cum_flag` |
| bus_busy | output | 1 | Transfer in progress |
| bto_flag | output | 1 | Sticky span time-out status |
| cum_flag | output | 1 | Sticky cumulative time-out status |
| irq | output | 1 | Combined interrupt request |
| fsm_rst_req | output | 1 | One-cycle protocol engine reset request |

## Verification
A busy state that is wrong inverts the span timer's condition. It shows on `bus_busy` one clock after the missed START or STOP, and it shows on `bto_flag` either one limit period early or never. A counter that fails to restart or miscounts ticks moves the flag edge by at least one cycle, so the bench samples the cycle before and the cycle of the expected edge. A timer that wrongly re-arms after expiry shows as a flag that returns after a clear, with no change on the lines. A window that is left open after ACK or STOP shows as a `cum_flag` that should not appear.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
    localparam int CNT_W = 14;
    localparam int LIM_W = 8;

    typedef enum logic {
        BUS_IDLE,
        BUS_ACTIVE
    } bus_state_e;

    typedef enum logic [1:0] {
        TMR_WAIT,
        TMR_COUNT,
        TMR_EXPIRED
    } tmr_state_e;

    typedef enum logic [1:0] {
        CUM_IDLE,
        CUM_WINDOW,
        CUM_EXPIRED
    } cum_state_e;
endpackage

// File: rtl/smbus_bus_tracker.sv
module smbus_bus_tracker
    import smbus_tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy_o,
    output logic start_o,
    output logic stop_o
);
    bus_state_e state_q, state_d;
    logic       scl_q, sda_q;

    // previous samples, reset high (released lines)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_q & scl_i & sda_q & ~sda_i;
        stop_o  = scl_q & scl_i & ~sda_q & sda_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!mon_en) begin
            state_d = BUS_IDLE;
        end else begin
            unique case (state_q)
                BUS_IDLE:   if (start_o) state_d = BUS_ACTIVE;
                BUS_ACTIVE: if (stop_o)  state_d = BUS_IDLE;
                default:    state_d = BUS_IDLE;
            endcase
        end
    end

    always_comb busy_o = (state_q == BUS_ACTIVE);
endmodule

// File: rtl/smbus_span_timer.sv
module smbus_span_timer
    import smbus_tmo_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [LW-1:0] limit_i,
    output logic          expire_o
);
    localparam int SHIFT = CW - LW;

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] target, cnt_inc;

    always_comb begin
        target  = {limit_i, {SHIFT{1'b0}}};
        cnt_inc = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (!run_i) begin
            state_d = TMR_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_WAIT, TMR_COUNT: begin
                    if (tick_i && (limit_i != '0)) begin
                        if (cnt_inc == target) begin
                            state_d  = TMR_EXPIRED;
                            cnt_d    = '0;
                            expire_o = 1'b1;
                        end else begin
                            state_d = TMR_COUNT;
                            cnt_d   = cnt_inc;
                        end
                    end
                end
                TMR_EXPIRED: state_d = TMR_EXPIRED;
                default:     state_d = TMR_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/smbus_cum_timer.sv
module smbus_cum_timer
    import smbus_tmo_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          ctrl_role_i,
    input  logic          ack_i,
    input  logic          scl_i,
    input  logic          tick_i,
    input  logic [LW-1:0] limit_i,
    output logic          expire_o
);
    localparam int SHIFT = CW - LW;

    cum_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] target, cnt_inc;
    logic          win_end;

    always_comb begin
        target  = {limit_i, {SHIFT{1'b0}}};
        cnt_inc = cnt_q + 1'b1;
        win_end = stop_i | (ctrl_role_i & ack_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CUM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (!en_i) begin
            state_d = CUM_IDLE;
            cnt_d   = '0;
        end else if (start_i) begin
            state_d = CUM_WINDOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CUM_IDLE: state_d = CUM_IDLE;
                CUM_WINDOW: begin
                    if (win_end) begin
                        state_d = CUM_IDLE;
                        cnt_d   = '0;
                    end else if (tick_i && !scl_i && (limit_i != '0)) begin
                        if (cnt_inc == target) begin
                            state_d  = CUM_EXPIRED;
                            cnt_d    = '0;
                            expire_o = 1'b1;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                CUM_EXPIRED: if (win_end) state_d = CUM_IDLE;
                default:     state_d = CUM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smbus_tmo_monitor.sv
module smbus_tmo_monitor
    import smbus_tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             tick_i,
    input  logic             mon_en,
    input  logic             idle_mode,
    input  logic             bto_en,
    input  logic             bto_ie,
    input  logic [LIM_W-1:0] bto_limit,
    input  logic             cum_en,
    input  logic             cum_ie,
    input  logic [LIM_W-1:0] cum_limit,
    input  logic             ctrl_role,
    input  logic             ack_i,
    input  logic             rst_on_to_en,
    input  logic             bto_clr,
    input  logic             cum_clr,
    output logic             bus_busy,
    output logic             bto_flag,
    output logic             cum_flag,
    output logic             irq,
    output logic             fsm_rst_req
);
    logic start_det, stop_det;
    logic span_run, span_exp, cum_exp;

    smbus_bus_tracker u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .mon_en  (mon_en),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .busy_o  (bus_busy),
        .start_o (start_det),
        .stop_o  (stop_det)
    );

    always_comb begin
        span_run = mon_en & bto_en &
                   (idle_mode ? (~bus_busy & scl_i & sda_i) : (bus_busy & ~scl_i));
    end

    smbus_span_timer #(.CW(CNT_W), .LW(LIM_W)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (span_run),
        .tick_i   (tick_i),
        .limit_i  (bto_limit),
        .expire_o (span_exp)
    );

    smbus_cum_timer #(.CW(CNT_W), .LW(LIM_W)) u_cum (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (mon_en & cum_en),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .ctrl_role_i (ctrl_role),
        .ack_i       (ack_i),
        .scl_i       (scl_i),
        .tick_i      (tick_i),
        .limit_i     (cum_limit),
        .expire_o    (cum_exp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bto_flag    <= 1'b0;
            cum_flag    <= 1'b0;
            fsm_rst_req <= 1'b0;
        end else begin
            bto_flag    <= (bto_flag & ~bto_clr) | span_exp;
            cum_flag    <= (cum_flag & ~cum_clr) | cum_exp;
            fsm_rst_req <= rst_on_to_en & (span_exp | cum_exp);
        end
    end

    always_comb irq = (bto_flag & bto_ie) | (cum_flag & cum_ie);
endmodule

// File: rtl/smbus_tmo_monitor_chk.sv
module smbus_tmo_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic mon_en,
    input logic bto_en,
    input logic cum_en,
    input logic bto_clr,
    input logic cum_clr,
    input logic rst_on_to_en,
    input logic bus_busy,
    input logic bto_flag,
    input logic cum_flag,
    input logic fsm_rst_req
);
    assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mon_en && $past(scl_i) && $past(sda_i) && scl_i && !sda_i) |=> bus_busy);

    assert_idle_on_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scl_i) && !$past(sda_i) && scl_i && sda_i) |=> !bus_busy);

    assert_bto_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bto_flag && !bto_clr) |=> bto_flag);

    assert_bto_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bto_flag) |-> $past(bto_en && mon_en));

    assert_cum_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cum_flag && !cum_clr) |=> cum_flag);

    assert_cum_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cum_flag) |-> $past(cum_en && mon_en));

    assert_rst_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_rst_req |-> $past(rst_on_to_en));

    assert_mon_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !bus_busy);
endmodule

bind smbus_tmo_monitor smbus_tmo_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .mon_en       (mon_en),
    .bto_en       (bto_en),
    .cum_en       (cum_en),
    .bto_clr      (bto_clr),
    .cum_clr      (cum_clr),
    .rst_on_to_en (rst_on_to_en),
    .bus_busy     (bus_busy),
    .bto_flag     (bto_flag),
    .cum_flag     (cum_flag),
    .fsm_rst_req  (fsm_rst_req)
);

// File: tb/sim_smbus_tmo_monitor.sv
module sim_smbus_tmo_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, tick = 1'b1;
    logic mon_en = 1'b0, idle_mode = 1'b0;
    logic bto_en = 1'b0, bto_ie = 1'b0, cum_en = 1'b0, cum_ie = 1'b0;
    logic [7:0] bto_lim = 8'd1, cum_lim = 8'd1;
    logic ctrl_role = 1'b0, ack = 1'b0, rst_en = 1'b0, bto_clr = 1'b0, cum_clr = 1'b0;
    logic busy, bflag, cflag, irq, rreq;
    logic tick_alt = 1'b0;
    logic cmp_on = 1'b0;
    logic done = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_tmo_monitor u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .tick_i(tick),
        .mon_en(mon_en), .idle_mode(idle_mode), .bto_en(bto_en), .bto_ie(bto_ie),
        .bto_limit(bto_lim), .cum_en(cum_en), .cum_ie(cum_ie), .cum_limit(cum_lim),
        .ctrl_role(ctrl_role), .ack_i(ack), .rst_on_to_en(rst_en),
        .bto_clr(bto_clr), .cum_clr(cum_clr), .bus_busy(busy), .bto_flag(bflag),
        .cum_flag(cflag), .irq(irq), .fsm_rst_req(rreq)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_busy, m_pscl, m_psda, m_bexp, m_cact, m_cexp, m_bf, m_cf, m_rr;
    int m_bcnt, m_ccnt;

    always @(posedge clk) begin
        bit st, sp, cond, bevt, cevt;
        if (!rst_n) begin
            m_busy = 0; m_pscl = 1; m_psda = 1; m_bexp = 0; m_cact = 0; m_cexp = 0;
            m_bf = 0; m_cf = 0; m_rr = 0; m_bcnt = 0; m_ccnt = 0;
        end else begin
            st = m_pscl && scl && m_psda && !sda;
            sp = m_pscl && scl && !m_psda && sda;
            bevt = 0; cevt = 0;
            cond = mon_en && bto_en && (idle_mode ? (!m_busy && scl && sda) : (m_busy && !scl));
            if (!cond) begin m_bcnt = 0; m_bexp = 0; end
            else if (!m_bexp && tick && bto_lim != 0) begin
                m_bcnt++;
                if (m_bcnt == bto_lim * 64) begin bevt = 1; m_bexp = 1; m_bcnt = 0; end
            end
            if (!(mon_en && cum_en)) begin m_cact = 0; m_cexp = 0; m_ccnt = 0; end
            else if (st) begin m_cact = 1; m_cexp = 0; m_ccnt = 0; end
            else if (m_cact && (sp || (ctrl_role && ack))) begin m_cact = 0; m_cexp = 0; m_ccnt = 0; end
            else if (m_cact && !m_cexp && tick && !scl && cum_lim != 0) begin
                m_ccnt++;
                if (m_ccnt == cum_lim * 64) begin cevt = 1; m_cexp = 1; end
            end
            if (!mon_en) m_busy = 0;
            else if (st) m_busy = 1;
            else if (sp) m_busy = 0;
            m_bf = (m_bf && !bto_clr) || bevt;
            m_cf = (m_cf && !cum_clr) || cevt;
            m_rr = rst_en && (bevt || cevt);
            m_pscl = scl; m_psda = sda;
        end
    end

    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            chk("R1 busy model", busy, m_busy);
            chk("R4 bto_flag model", bflag, m_bf);
            chk("R7 cum_flag model", cflag, m_cf);
            chk("R8 irq model", irq, (m_bf && bto_ie) || (m_cf && cum_ie));
            chk("R9 rst_req model", rreq, m_rr);
        end
    end

    always @(negedge clk) if (tick_alt) tick = ~tick;

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pchk(string req, logic act, logic exp);
        #2 chk(req, act, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cmp_on = 1'b1;
        pchk("R1 reset busy", busy, 1'b0);
        pchk("R4 reset bto_flag", bflag, 1'b0);
        pchk("R7 reset cum_flag", cflag, 1'b0);
        pchk("R9 reset rst_req", rreq, 1'b0);

        // R1/R2/R3: clock-low timing, limit 1 = 64 ticks
        mon_en = 1; bto_en = 1; bto_ie = 1; bto_lim = 8'd1; idle_mode = 0;
        cyc(2);
        sda = 0; cyc(1);
        pchk("R1 busy after START", busy, 1'b1);
        scl = 0;
        cyc(63); pchk("R3 clock-low 63 ticks no time-out", bflag, 1'b0);
        cyc(1);  pchk("R3 clock-low 64 ticks time-out", bflag, 1'b1);
        pchk("R8 irq follows flag", irq, 1'b1);
        pchk("R9 no request when disabled", rreq, 1'b0);
        bto_ie = 0; #1 pchk("R8 irq masked", irq, 1'b0);
        bto_ie = 1;
        cyc(20); bto_clr = 1; cyc(1); bto_clr = 0;
        pchk("R4 write-1 clear", bflag, 1'b0);
        cyc(80); pchk("R6 no retrigger while still low", bflag, 1'b0);

        // R5: SCL high restarts the low count
        scl = 1; cyc(1); scl = 0;
        cyc(40); scl = 1; cyc(1); scl = 0;
        cyc(63); pchk("R5 restart on SCL high", bflag, 1'b0);
        cyc(1);  pchk("R5 time-out after restart", bflag, 1'b1);
        bto_clr = 1; cyc(1); bto_clr = 0;

        // R2: idle mode; STOP then idle time
        idle_mode = 1;
        scl = 1; cyc(1);
        sda = 1; cyc(1);
        pchk("R1 idle after STOP", busy, 1'b0);
        cyc(63); pchk("R2 idle 64 ticks not yet", bflag, 1'b0);
        cyc(1);  pchk("R2 idle time-out", bflag, 1'b1);
        bto_clr = 1; cyc(1); bto_clr = 0;

        // R11: half-rate tick
        sda = 0; cyc(1); sda = 1; cyc(2);
        tick_alt = 1;
        sda = 0; cyc(1); sda = 1;
        cyc(100); pchk("R11 half-rate tick slower", bflag, 1'b0);
        cyc(40);  pchk("R11 half-rate tick reaches limit", bflag, 1'b1);
        tick_alt = 0; tick = 1;
        bto_clr = 1; cyc(1); bto_clr = 0;

        // R3: limit zero disables
        bto_lim = 8'd0; sda = 0; cyc(1); sda = 1;
        cyc(300); pchk("R3 limit zero never times out", bflag, 1'b0);
        bto_en = 0; bto_lim = 8'd1; idle_mode = 0;

        // R7/R9: cumulative, target role
        cum_en = 1; cum_ie = 1; cum_lim = 8'd1; ctrl_role = 0; rst_en = 1;
        cyc(2);
        sda = 0; cyc(1);
        scl = 0; cyc(32);
        scl = 1; cyc(5);
        scl = 0; cyc(31);
        pchk("R7 cumulative 63 ticks", cflag, 1'b0);
        cyc(1);
        pchk("R7 cumulative 64 ticks", cflag, 1'b1);
        pchk("R9 reset request pulse", rreq, 1'b1);
        cyc(1);
        pchk("R9 reset request one cycle", rreq, 1'b0);
        cum_clr = 1; cyc(1); cum_clr = 0;
        pchk("R7 cumulative clear", cflag, 1'b0);
        scl = 1; cyc(1); sda = 1; cyc(2);

        // R7: controller role window ends at ACK
        ctrl_role = 1;
        sda = 0; cyc(1);
        scl = 0; cyc(20);
        ack = 1; cyc(1); ack = 0;
        cyc(80);
        pchk("R7 controller window closed at ACK", cflag, 1'b0);

        // R10: monitor disable
        cum_flag_set: begin
            scl = 1; cyc(1); sda = 1; cyc(1);
            sda = 0; cyc(1);
            pchk("R10 busy before disable", busy, 1'b1);
            bto_en = 1; bto_ie = 1; scl = 0; cyc(70);
            pchk("R10 flag set before disable", bflag, 1'b1);
            mon_en = 0; cyc(1);
            pchk("R10 busy cleared by disable", busy, 1'b0);
            pchk("R10 flag kept", bflag, 1'b1);
            bto_clr = 1; cyc(1); bto_clr = 0;
            cyc(100);
            pchk("R10 no time-out while disabled", bflag, 1'b0);
        end

        cyc(2);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule